// File: doc/BRIEF.md
# Supply Restore Wake Controller

This always-on block runs from a slow clock while the main supply of a chip is switched off. It watches four wake pins, an event line from a long countdown timer and an active-low reset pin. When any enabled source qualifies, it raises a supply-enable output so that external power circuitry brings the main rail back. Each pin can be set to level or edge detection and to either polarity. An optional three-sample glitch filter sits in front of detection.

The supply-enable output has two modes. In level mode it stays high until a hibernate request drops it. In pulse mode it emits a high pulse of a programmable width, and it may be driven open-drain in that mode only. Sticky per-source status bits hold the wake cause across the power cycle, so that software can read it once power returns. A lock bit freezes the reset-pin wake enable, and the lock bit itself, until the next reset. A separate general-purpose output follows one register bit.

Access goes through a small synchronous write port with a combinational read port of four 8-bit registers. Register 0 holds edge-select bits in [7:4] and pin status in [3:0]. Register 1 holds polarity bits at even positions. Register 2 is the mode register. Register 3 holds the pulse width.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While reset is held and right after it: sup_o=1, sup_oe=1, gpo_o=0, register 0 reads 0x00, register 1 reads 0x00, register 2 reads 0x00 and register 3 reads 0x08.
- R2: A pin whose type bit (register 0 bit i+4) is 0 uses level detection. The pin is active at high when its polarity bit (register 1 bit 2*i) is 1, and at low when that bit is 0. While the pin is active, register 0 bit i is set and, in level mode, sup_o goes high at the next clock edge.
- R3: A pin whose type bit is 1 triggers only on a transition into its active level (rising for polarity 1, falling for polarity 0). A pin held at its active level, or a transition the other way, raises no event.
- R4: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the bit set.
- R5: With glitch filtering on (register 2 bit 2), a pin change is seen only after it has stayed at the new value for 3 consecutive clock samples, so a 2-cycle pulse raises no event.
- R6: A rising edge on tmr_evt is a wake source and sets register 2 bit 6. A level that stays high does not set the bit again.
- R7: The active-low reset pin wakes the block and sets register 2 bit 7, but only while register 2 bit 3 is 1.
- R8: Once register 2 bit 4 (lock) is 1, writes to bits 4 and 3 of register 2 are ignored until reset. The other mode bits stay writable.
- R9: In level mode (register 2 bit 0 = 0), hib_req drives sup_o low at the next edge. A wake in the same cycle wins and sup_o stays high.
- R10: In pulse mode (register 2 bit 0 = 1), sup_o idles low, and a wake gives a high pulse of exactly max(W,1) cycles, where W is register 3. Wakes during a pulse do not extend it.
- R11: Open-drain (register 2 bit 1) is stored only when the same write also sets pulse mode. With open-drain on, sup_oe = not sup_o. Otherwise sup_oe = 1.
- R12: gpo_o follows register 2 bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| wake_pin | input | 4 | Wake pins |
| tmr_evt | input | 1 | Countdown timer event |
| rst_pin_n | input | 1 | Active-low reset pin |
| hib_req | input | 1 | Hibernate request, drops supply in level mode |
| sup_o | output | 1 | Supply-enable output value |
| sup_oe | output | 1 | Supply-enable drive enable |
| gpo_o | output | 1 | General-purpose output |

## Verification
The bench separates level from edge detection by using a pin that is already at its active level when status is cleared. A design that treats every type as level would wake there. A design that treats every type as edge would miss a held level across a hibernate request. A 2-cycle pulse with filtering on must not wake, so a filter that is too short or bypassed would be caught. The lock, the open-drain gating and the exact pulse length are each checked by read-back or by counting cycles. A lock that fails to hold, open-drain left on in level mode, or a pulse one cycle too long or too short would show up as a wrong value.

// File: rtl/pwk_pkg.sv
`timescale 1ns/1ps
package pwk_pkg;
    localparam int NUM_PIN = 4;

    typedef enum logic [1:0] {
        A_PINCFG = 2'd0,
        A_POL    = 2'd1,
        A_MODE   = 2'd2,
        A_WIDTH  = 2'd3
    } pwk_addr_e;

    typedef struct packed {
        logic rst_stat;
        logic tmr_stat;
        logic gpo;
        logic lock;
        logic rst_en;
        logic glitch_en;
        logic od_en;
        logic pulse_en;
    } pwk_mode_t;

    function automatic logic [7:0] spread_pol(input logic [NUM_PIN-1:0] p);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < NUM_PIN; i++) r[2*i] = p[i];
        return r;
    endfunction
endpackage

// File: rtl/pwk_filter.sv
`timescale 1ns/1ps
module pwk_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] hist;
    logic           held;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            held <= 1'b0;
        end else begin
            hist <= {hist[LEN-2:0], din};
            if (&hist)       held <= 1'b1;
            else if (~|hist) held <= 1'b0;
        end
    end

    assign dout = en ? held : din;
endmodule

// File: rtl/pwk_detect.sv
`timescale 1ns/1ps
module pwk_detect (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic pol,
    input  logic edge_sel,
    output logic evt
);
    logic act, prev;

    assign act = pol ? din : ~din;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= act;
    end

    assign evt = edge_sel ? (act & ~prev) : act;
endmodule

// File: rtl/pwk_outdrv.sv
`timescale 1ns/1ps
module pwk_outdrv #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wake,
    input  logic            hib,
    input  logic            pulse_en,
    input  logic            od_en,
    input  logic [PW_W-1:0] width,
    output logic            sup_o,
    output logic            sup_oe
);
    logic            lvl;
    logic [PW_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b1;
            cnt <= '0;
        end else begin
            if (wake)     lvl <= 1'b1;
            else if (hib) lvl <= 1'b0;
            if (cnt != '0)
                cnt <= cnt - 1'b1;
            else if (wake && pulse_en)
                cnt <= (width == '0) ? PW_W'(1) : width;
        end
    end

    assign sup_o  = pulse_en ? (cnt != '0) : lvl;
    assign sup_oe = od_en ? ~sup_o : 1'b1;
endmodule

// File: rtl/pwr_wake_ctrl.sv
`timescale 1ns/1ps
module pwr_wake_ctrl
    import pwk_pkg::*;
#(
    parameter int FILT_LEN = 3,
    parameter int PW_W     = 8,
    parameter int PW_RST   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [NUM_PIN-1:0] wake_pin,
    input  logic               tmr_evt,
    input  logic               rst_pin_n,
    input  logic               hib_req,
    output logic               sup_o,
    output logic               sup_oe,
    output logic               gpo_o
);
    localparam int NSRC = NUM_PIN + 1;

    logic [NUM_PIN-1:0] type_q, pol_q, pin_stat, pin_evt, pin_clr;
    pwk_mode_t          mode_q;
    logic [PW_W-1:0]    width_q;
    logic [NSRC-1:0]    raw_in, filt;
    logic               tmr_e, rst_raw_e, rst_e, wake;
    logic               wr_cfg, wr_pol, wr_mode, wr_width;

    assign wr_cfg   = wr_en && (addr == A_PINCFG);
    assign wr_pol   = wr_en && (addr == A_POL);
    assign wr_mode  = wr_en && (addr == A_MODE);
    assign wr_width = wr_en && (addr == A_WIDTH);
    assign pin_clr  = wr_cfg ? wdata[NUM_PIN-1:0] : '0;

    assign raw_in = {rst_pin_n, wake_pin};

    for (genvar g = 0; g < NSRC; g++) begin : g_filt
        pwk_filter #(.LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst(rst), .en(mode_q.glitch_en),
            .din(raw_in[g]), .dout(filt[g])
        );
    end

    for (genvar g = 0; g < NUM_PIN; g++) begin : g_det
        pwk_detect u_det (
            .clk(clk), .rst(rst), .din(filt[g]), .pol(pol_q[g]),
            .edge_sel(type_q[g]), .evt(pin_evt[g])
        );
    end

    pwk_detect u_tmr_det (
        .clk(clk), .rst(rst), .din(tmr_evt), .pol(1'b1),
        .edge_sel(1'b1), .evt(tmr_e)
    );

    pwk_detect u_rst_det (
        .clk(clk), .rst(rst), .din(filt[NUM_PIN]), .pol(1'b0),
        .edge_sel(1'b0), .evt(rst_raw_e)
    );

    assign rst_e = rst_raw_e & mode_q.rst_en;
    assign wake  = (|pin_evt) | tmr_e | rst_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q   <= '0;
            pol_q    <= '0;
            pin_stat <= '0;
            mode_q   <= '0;
            width_q  <= PW_W'(PW_RST);
        end else begin
            if (wr_cfg) type_q <= wdata[7:4];
            pin_stat <= (pin_stat & ~pin_clr) | pin_evt;
            if (wr_pol)
                for (int i = 0; i < NUM_PIN; i++) pol_q[i] <= wdata[2*i];
            if (wr_mode) begin
                mode_q.pulse_en  <= wdata[0];
                mode_q.od_en     <= wdata[1] & wdata[0];
                mode_q.glitch_en <= wdata[2];
                mode_q.gpo       <= wdata[5];
                if (!mode_q.lock) begin
                    mode_q.rst_en <= wdata[3];
                    mode_q.lock   <= wdata[4];
                end
            end
            mode_q.tmr_stat <= (mode_q.tmr_stat & ~(wr_mode & wdata[6])) | tmr_e;
            mode_q.rst_stat <= (mode_q.rst_stat & ~(wr_mode & wdata[7])) | rst_e;
            if (wr_width) width_q <= wdata[PW_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (pwk_addr_e'(addr))
            A_PINCFG: rdata = {type_q, pin_stat};
            A_POL:    rdata = spread_pol(pol_q);
            A_MODE:   rdata = mode_q;
            default:  rdata[PW_W-1:0] = width_q;
        endcase
    end

    pwk_outdrv #(.PW_W(PW_W)) u_drv (
        .clk(clk), .rst(rst), .wake(wake), .hib(hib_req),
        .pulse_en(mode_q.pulse_en), .od_en(mode_q.od_en), .width(width_q),
        .sup_o(sup_o), .sup_oe(sup_oe)
    );

    assign gpo_o = mode_q.gpo;
endmodule

// File: rtl/pwk_chk.sv
`timescale 1ns/1ps
module pwk_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          pulse_en,
    input logic          od_en,
    input logic          lock,
    input logic          rst_en,
    input logic          wake,
    input logic          hib_req,
    input logic          wr_mode,
    input logic          sup_o,
    input logic          sup_oe,
    input logic [NP-1:0] pin_stat,
    input logic [NP-1:0] pin_clr
);
    AST_OD_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        od_en |-> pulse_en); // R11
    AST_OE_PUSHPULL: assert property (@(posedge clk) disable iff (rst)
        !od_en |-> sup_oe); // R11
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        lock |=> (lock && $stable(rst_en))); // R8
    AST_LEVEL_WAKE: assert property (@(posedge clk) disable iff (rst)
        (!pulse_en && wake && !wr_mode) |=> sup_o); // R9
    AST_HIB_DROP: assert property (@(posedge clk) disable iff (rst)
        (!pulse_en && hib_req && !wake && !wr_mode) |=> !sup_o); // R9
    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (pulse_en && wake && !sup_o && !wr_mode) |=> sup_o); // R10

    for (genvar g = 0; g < NP; g++) begin : g_sticky
        AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (pin_stat[g] && !pin_clr[g]) |=> pin_stat[g]); // R4
    end
endmodule

bind pwr_wake_ctrl pwk_chk #(.NP(pwk_pkg::NUM_PIN)) u_chk (
    .clk(clk), .rst(rst), .pulse_en(mode_q.pulse_en), .od_en(mode_q.od_en),
    .lock(mode_q.lock), .rst_en(mode_q.rst_en), .wake(wake),
    .hib_req(hib_req), .wr_mode(wr_mode), .sup_o(sup_o), .sup_oe(sup_oe),
    .pin_stat(pin_stat), .pin_clr(pin_clr)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] wake_pin = '0;
    logic       tmr_evt = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic       hib_req = 1'b0;
    logic       sup_o, sup_oe, gpo_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_wake_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wake_pin(wake_pin), .tmr_evt(tmr_evt),
        .rst_pin_n(rst_pin_n), .hib_req(hib_req), .sup_o(sup_o),
        .sup_oe(sup_oe), .gpo_o(gpo_o)
    );

    // [7:6] pin, [5] edge type, [4] polarity, [3] level before clear,
    // [2] level after clear, [1] expected wake
    localparam logic [7:0] VEC [8] = '{
        8'b00_0_1_0_1_1_0,
        8'b01_0_0_1_0_1_0,
        8'b10_1_1_0_1_1_0,
        8'b11_1_0_1_0_1_0,
        8'b10_1_1_1_1_0_0,
        8'b00_0_1_1_1_1_0,
        8'b01_1_1_1_0_0_0,
        8'b11_0_1_0_0_0_0
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic hib_pulse();
        @(negedge clk); hib_req = 1'b1;
        @(negedge clk); hib_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // all pins rising-edge, pins low, supply dropped, status cleared
    task automatic quiet(input logic [7:0] mode);
        wake_pin = '0;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h55);
        wr(2'd2, mode | 8'hC0);
        idle(4);
        hib_pulse();
        wr(2'd0, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int hi;

        // R1 reset state
        idle(3);
        chk(sup_o == 1'b1, "R1 sup_o", sup_o, 1);
        chk(sup_oe == 1'b1, "R1 sup_oe", sup_oe, 1);
        chk(gpo_o == 1'b0, "R1 gpo_o", gpo_o, 0);
        rd(2'd0, v); chk(v == 8'h00, "R1 reg0", v, 8'h00);
        rd(2'd1, v); chk(v == 8'h00, "R1 reg1", v, 8'h00);
        rd(2'd2, v); chk(v == 8'h00, "R1 reg2", v, 8'h00);
        rd(2'd3, v); chk(v == 8'h08, "R1 reg3", v, 8'h08);
        @(negedge clk); rst = 1'b0;

        // R2/R3 table of pin detection cases
        for (int k = 0; k < 8; k++) begin
            int idx;
            logic [3:0] tv, pv;
            logic [7:0] pb;
            idx = int'(VEC[k][7:6]);
            tv = 4'hF; tv[idx] = VEC[k][5];
            pv = 4'hF; pv[idx] = VEC[k][4];
            pb = '0;
            for (int j = 0; j < 4; j++) pb[2*j] = pv[j];
            wake_pin = '0;
            wr(2'd0, {tv, 4'hF});
            wr(2'd1, pb);
            @(negedge clk); wake_pin[idx] = VEC[k][3];
            idle(3);
            hib_pulse();
            wr(2'd0, {tv, 4'hF});
            wake_pin[idx] = VEC[k][2];
            idle(2);
            rd(2'd0, v);
            chk(v[idx] == VEC[k][1], VEC[k][5] ? "R3 edge status" : "R2 level status",
                v[idx], VEC[k][1]);
            chk(sup_o == VEC[k][1], VEC[k][5] ? "R3 edge supply" : "R2 level supply",
                sup_o, VEC[k][1]);
        end

        // R4 sticky status, write-one-to-clear
        quiet(8'h00);
        @(negedge clk); wake_pin = 4'b0011;
        @(negedge clk); wake_pin = 4'b0000;
        idle(1);
        wr(2'd0, 8'hF1);
        rd(2'd0, v); chk(v[3:0] == 4'b0010, "R4 partial clear", v[3:0], 4'b0010);
        wr(2'd0, 8'hF0);
        rd(2'd0, v); chk(v[3:0] == 4'b0010, "R4 zero write keeps", v[3:0], 4'b0010);

        // R5 glitch filter
        quiet(8'h04);
        wr(2'd0, 8'hEF);
        hib_pulse();
        wr(2'd0, 8'hEF);
        chk(sup_o == 1'b0, "R5 supply low before", sup_o, 0);
        @(negedge clk); wake_pin[0] = 1'b1;
        idle(2); wake_pin[0] = 1'b0;
        idle(6);
        rd(2'd0, v); chk(v[0] == 1'b0, "R5 short pulse status", v[0], 0);
        chk(sup_o == 1'b0, "R5 short pulse supply", sup_o, 0);
        wake_pin[0] = 1'b1;
        idle(8);
        rd(2'd0, v); chk(v[0] == 1'b1, "R5 long pulse status", v[0], 1);
        chk(sup_o == 1'b1, "R5 long pulse supply", sup_o, 1);
        wake_pin[0] = 1'b0;

        // R6 timer rising edge
        quiet(8'h00);
        chk(sup_o == 1'b0, "R6 supply low before", sup_o, 0);
        @(negedge clk); tmr_evt = 1'b1;
        @(negedge clk);
        chk(sup_o == 1'b1, "R6 timer wake", sup_o, 1);
        rd(2'd2, v); chk(v[6] == 1'b1, "R6 timer status", v[6], 1);
        wr(2'd2, 8'h40);
        idle(3);
        rd(2'd2, v); chk(v[6] == 1'b0, "R6 held level no re-set", v[6], 0);
        tmr_evt = 1'b0;

        // R7 reset pin wake
        quiet(8'h00);
        @(negedge clk); rst_pin_n = 1'b0;
        idle(3);
        chk(sup_o == 1'b0, "R7 disabled no wake", sup_o, 0);
        rd(2'd2, v); chk(v[7] == 1'b0, "R7 disabled no status", v[7], 0);
        wr(2'd2, 8'h08);
        idle(1);
        chk(sup_o == 1'b1, "R7 enabled wake", sup_o, 1);
        rd(2'd2, v); chk(v[7] == 1'b1, "R7 status", v[7], 1);
        rst_pin_n = 1'b1;
        wr(2'd2, 8'h80);

        // R8 lock
        wr(2'd2, 8'h18);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk((v & 8'h18) == 8'h18, "R8 lock holds", v & 8'h18, 8'h18);
        wr(2'd2, 8'h04);
        rd(2'd2, v); chk(v[2] == 1'b1, "R8 other bits writable", v[2], 1);

        // R9 hibernate versus held wake
        quiet(8'h00);
        wr(2'd0, 8'hEF);
        @(negedge clk); wake_pin[0] = 1'b1;
        idle(2);
        hib_pulse();
        idle(1);
        chk(sup_o == 1'b1, "R9 wake beats hibernate", sup_o, 1);
        wake_pin[0] = 1'b0;
        idle(1);
        hib_pulse();
        chk(sup_o == 1'b0, "R9 hibernate drops supply", sup_o, 0);
        wr(2'd0, 8'hFF);

        // R10 pulse width
        quiet(8'h00);
        wr(2'd3, 8'd5);
        wr(2'd2, 8'h01);
        chk(sup_o == 1'b0, "R10 pulse idle low", sup_o, 0);
        @(negedge clk); tmr_evt = 1'b1;
        hi = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (sup_o) hi++;
            if (c == 1) begin tmr_evt = 1'b0; @(negedge clk); if (sup_o) hi++; tmr_evt = 1'b1; end
        end
        chk(hi == 5, "R10 width 5", hi, 5);
        tmr_evt = 1'b0;
        wr(2'd3, 8'd0);
        @(negedge clk); tmr_evt = 1'b1;
        hi = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (sup_o) hi++;
        end
        chk(hi == 1, "R10 width 0 gives 1", hi, 1);
        tmr_evt = 1'b0;

        // R11 open-drain gating
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk(v[1:0] == 2'b00, "R11 od refused in level", v[1:0], 0);
        chk(sup_oe == 1'b1, "R11 push-pull oe", sup_oe, 1);
        wr(2'd3, 8'd4);
        wr(2'd2, 8'h03);
        rd(2'd2, v); chk(v[1:0] == 2'b11, "R11 od kept in pulse", v[1:0], 3);
        chk(sup_oe == 1'b1, "R11 od drive low", sup_oe, 1);
        @(negedge clk); tmr_evt = 1'b1;
        @(negedge clk);
        chk(sup_o == 1'b1 && sup_oe == 1'b0, "R11 od release high", sup_oe, 0);
        tmr_evt = 1'b0;
        idle(6);

        // R12 general output
        wr(2'd2, 8'h20);
        chk(gpo_o == 1'b1, "R12 gpo high", gpo_o, 1);
        wr(2'd2, 8'h00);
        chk(gpo_o == 1'b0, "R12 gpo low", gpo_o, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule